// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter advanced by a slow tick enable (nominally one tick per millisecond, with a loose tolerance). The timeout is therefore a count of ticks, not a time. A 4-bit exponent sets the timeout. Software must strobe the feed input before the count runs out. An optional early window makes a feed that comes too soon an error as well.

Either failure, an expiry or an early feed, leads to one of two actions. In reset mode the block emits a one-cycle reset request. In no-reset mode it sets a sticky timeout flag instead; the flag is gated by an enable and cleared by a write-one strobe. Counting can be paused while the system sleeps or while a debugger halts it. Disabling the block parks the counter at zero.

Top module: `wwdt_core`

## Requirements
- R1: After reset, rst_req, tmo_flag and tmo_irq are all 0.
- R2: With period select n (4-bit, 0..15), the P-th counted tick after a restart is an expiry, where P = (8 << n) + 1. The action appears on the outputs in the cycle after the clock edge that counts that tick.
- R3: A feed while enabled restarts the count from zero, so the next expiry needs a full P counted ticks.
- R4: With window select k (3-bit, 1..7), a feed while the count is below k*(1 << n) is an early feed. An early feed takes the same action as an expiry and also restarts the count. With k = 0, a feed at any count is legal.
- R5: In reset mode (cfg_no_reset = 0), an expiry or early feed makes rst_req high for exactly one cycle, and the count restarts.
- R6: In no-reset mode (cfg_no_reset = 1), an expiry or early feed sets tmo_flag and never asserts rst_req; tmo_irq equals tmo_flag AND irq_en.
- R7: A tmo_clr strobe clears tmo_flag; when a new event and tmo_clr arrive in the same cycle, the flag ends up set.
- R8: While sleep_in is high and cfg_run_sleep is 0, ticks are not counted; with cfg_run_sleep = 1 sleep has no effect.
- R9: While dbg_halt is high and cfg_run_dbg is 0, ticks are not counted; with cfg_run_dbg = 1 debug halt has no effect.
- R10: While cfg_enable is 0 the count is held at zero, feeds are ignored and no event occurs; re-enabling starts a fresh full period.
- R11: Only cycles with tick_en high advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow tick enable, one cycle per tick |
| cfg_enable | input | 1 | Watchdog enable |
| cfg_period | input | 4 | Period exponent n |
| cfg_window | input | 3 | Early window in eighths, 0 = off |
| cfg_no_reset | input | 1 | 1 = flag instead of reset request |
| cfg_run_sleep | input | 1 | 1 = keep counting while asleep |
| cfg_run_dbg | input | 1 | 1 = keep counting during debug halt |
| feed | input | 1 | Feed strobe |
| sleep_in | input | 1 | System sleep status |
| dbg_halt | input | 1 | Debug halt status |
| irq_en | input | 1 | Timeout interrupt enable |
| tmo_clr | input | 1 | Write-one-to-clear strobe for tmo_flag |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_irq | output | 1 | Gated timeout interrupt |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest cases are the exact edges of the early window and of the period. A feed at count k*2^n - 1 must be flagged, while a feed one tick later must not. The stimulus reaches these points by enabling the block, so that the count starts from a known zero, and then stepping an exact number of ticks before the feed. A flag clear that lands in the same cycle as a fresh expiry is reached the same way, by timing the clear strobe onto the P-th tick.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int PSEL_W = 4;
  localparam int WSEL_W = 3;
  localparam int BASE_SH = 3;
  localparam int CNT_W = BASE_SH + (1 << PSEL_W) - 1 + 1;
endpackage

// File: rtl/wwdt_timer.sv
module wwdt_timer
  import wwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              advance,
  input  logic              feed,
  input  logic [PSEL_W-1:0] period,
  input  logic [WSEL_W-1:0] window,
  output logic              expire,
  output logic              early_feed
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit, win_bound;

  always_comb begin
    limit     = (CNT_W'(1) << (BASE_SH + int'(period))) + CNT_W'(1);
    win_bound = CNT_W'(window) << period;
    early_feed = enable && feed && (window != '0) && (cnt_q < win_bound);
    expire     = enable && advance && !feed && (cnt_q >= limit - CNT_W'(1));
    cnt_d = cnt_q;
    if (!enable || feed || expire) cnt_d = '0;
    else if (advance)              cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_disabled_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));
  assert_feed_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && feed) |=> (cnt_q == '0));
  assert_no_tick_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !advance && !feed) |=> $stable(cnt_q));
endmodule

// File: rtl/wwdt_action.sv
module wwdt_action (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic no_reset,
  input  logic clr,
  output logic flag,
  output logic rst_req
);
  logic flag_d, req_d;

  always_comb begin
    req_d  = evt && !no_reset;
    flag_d = flag;
    if (evt && no_reset) flag_d = 1'b1;
    else if (clr)        flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      flag    <= flag_d;
      rst_req <= req_d;
    end
  end

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_no_req_irqmode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(!no_reset));
  assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(evt && no_reset));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(evt && no_reset)) |=> !flag);
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
  import wwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cfg_enable,
  input  logic [PSEL_W-1:0] cfg_period,
  input  logic [WSEL_W-1:0] cfg_window,
  input  logic              cfg_no_reset,
  input  logic              cfg_run_sleep,
  input  logic              cfg_run_dbg,
  input  logic              feed,
  input  logic              sleep_in,
  input  logic              dbg_halt,
  input  logic              irq_en,
  input  logic              tmo_clr,
  output logic              tmo_flag,
  output logic              tmo_irq,
  output logic              rst_req
);
  logic advance, expire, early_feed, evt;

  assign advance = tick_en && (cfg_run_sleep || !sleep_in) && (cfg_run_dbg || !dbg_halt);
  assign evt     = expire || early_feed;
  assign tmo_irq = tmo_flag && irq_en;

  wwdt_timer u_timer (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .advance(advance),
    .feed(feed), .period(cfg_period), .window(cfg_window),
    .expire(expire), .early_feed(early_feed)
  );

  wwdt_action u_action (
    .clk(clk), .rst_n(rst_n), .evt(evt), .no_reset(cfg_no_reset),
    .clr(tmo_clr), .flag(tmo_flag), .rst_req(rst_req)
  );

  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !rst_req);
endmodule

// File: tb/wwdt_core_bench.sv
module wwdt_core_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic tick_en, cfg_enable, cfg_no_reset, cfg_run_sleep, cfg_run_dbg;
  logic [3:0] cfg_period;
  logic [2:0] cfg_window;
  logic feed, sleep_in, dbg_halt, irq_en, tmo_clr;
  logic tmo_flag, tmo_irq, rst_req;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wwdt_core u_wwdt_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_enable(cfg_enable),
    .cfg_period(cfg_period), .cfg_window(cfg_window), .cfg_no_reset(cfg_no_reset),
    .cfg_run_sleep(cfg_run_sleep), .cfg_run_dbg(cfg_run_dbg), .feed(feed),
    .sleep_in(sleep_in), .dbg_halt(dbg_halt), .irq_en(irq_en), .tmo_clr(tmo_clr),
    .tmo_flag(tmo_flag), .tmo_irq(tmo_irq), .rst_req(rst_req)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic do_feed();
    feed = 1'b1; step(1); feed = 1'b0;
  endtask

  task automatic park();
    cfg_enable = 1'b0; tmo_clr = 1'b1; step(2); tmo_clr = 1'b0;
    cfg_window = '0; cfg_period = '0; cfg_no_reset = 1'b0;
    sleep_in = 1'b0; dbg_halt = 1'b0; cfg_run_sleep = 1'b0; cfg_run_dbg = 1'b0;
    tick_en = 1'b1; irq_en = 1'b0;
  endtask

  task automatic t_reset();
    chk(rst_req, 1'b0, "R1 rst_req");
    chk(tmo_flag, 1'b0, "R1 tmo_flag");
    chk(tmo_irq, 1'b0, "R1 tmo_irq");
  endtask

  task automatic t_period(input logic [3:0] n);
    int p;
    park(); p = (8 << n) + 1;
    cfg_period = n; cfg_enable = 1'b1;
    step(p - 1); chk(rst_req, 1'b0, "R2 before period end");
    step(1);     chk(rst_req, 1'b1, "R2 at period end / R5 pulse");
    step(1);     chk(rst_req, 1'b0, "R5 single cycle");
    step(p - 2); chk(rst_req, 1'b0, "R5 restart before end");
    step(1);     chk(rst_req, 1'b1, "R5 restarted period");
  endtask

  task automatic t_feed();
    park(); cfg_enable = 1'b1;
    step(7); do_feed();
    step(8); chk(rst_req, 1'b0, "R3 feed restarted count");
    step(1); chk(rst_req, 1'b1, "R3 expiry after feed");
  endtask

  task automatic t_window(input logic [3:0] n, input logic [2:0] k);
    int b;
    park(); b = int'(k) << n;
    cfg_period = n; cfg_window = k; cfg_enable = 1'b1;
    step(b - 1); do_feed(); chk(rst_req, 1'b1, "R4 early feed at bound-1");
    step(1); chk(rst_req, 1'b0, "R4 early pulse ends");
    step(b - 1); do_feed(); chk(rst_req, 1'b0, "R4 legal feed at bound");
  endtask

  task automatic t_window_off();
    park(); cfg_enable = 1'b1;
    step(1); do_feed(); chk(rst_req, 1'b0, "R4 window 0 feed legal");
  endtask

  task automatic t_irq_mode();
    park(); cfg_no_reset = 1'b1; cfg_enable = 1'b1;
    step(9);
    chk(tmo_flag, 1'b1, "R6 flag set");
    chk(rst_req, 1'b0, "R6 no reset request");
    chk(tmo_irq, 1'b0, "R6 irq masked");
    irq_en = 1'b1; #1;
    chk(tmo_irq, 1'b1, "R6 irq enabled");
    tmo_clr = 1'b1; step(1); tmo_clr = 1'b0;
    chk(tmo_flag, 1'b0, "R7 flag cleared");
    step(7); tmo_clr = 1'b1; step(1); tmo_clr = 1'b0;
    chk(tmo_flag, 1'b1, "R7 set wins over clear");
    irq_en = 1'b0; cfg_window = 3'd2; step(1); do_feed();
    chk(tmo_flag, 1'b1, "R6 early feed sets flag");
    chk(rst_req, 1'b0, "R6 early feed no reset");
  endtask

  task automatic t_sleep(input bit dbg, input bit run);
    park(); cfg_enable = 1'b1;
    if (dbg) cfg_run_dbg = run; else cfg_run_sleep = run;
    step(4);
    if (dbg) dbg_halt = 1'b1; else sleep_in = 1'b1;
    if (run) begin
      step(4); chk(rst_req, 1'b0, dbg ? "R9 run before end" : "R8 run before end");
      step(1); chk(rst_req, 1'b1, dbg ? "R9 counts when run set" : "R8 counts when run set");
    end else begin
      step(10);
      dbg_halt = 1'b0; sleep_in = 1'b0;
      step(4); chk(rst_req, 1'b0, dbg ? "R9 paused in halt" : "R8 paused in sleep");
      step(1); chk(rst_req, 1'b1, dbg ? "R9 resumes" : "R8 resumes");
    end
    dbg_halt = 1'b0; sleep_in = 1'b0;
  endtask

  task automatic t_disable();
    int seen;
    park(); cfg_enable = 1'b1; cfg_window = 3'd7;
    step(5); cfg_enable = 1'b0; seen = 0;
    for (int i = 0; i < 20; i++) begin
      feed = (i == 3); step(1);
      if (rst_req) seen++;
    end
    feed = 1'b0;
    chk(seen != 0, 1'b0, "R10 disabled quiet, feed ignored");
    cfg_window = '0; cfg_enable = 1'b1;
    step(8); chk(rst_req, 1'b0, "R10 fresh period before end");
    step(1); chk(rst_req, 1'b1, "R10 fresh period end");
  endtask

  task automatic t_tick();
    park(); cfg_enable = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick_en = 1'b1; step(1); tick_en = 1'b0; step(1);
    end
    chk(rst_req, 1'b0, "R11 eight ticks only");
    tick_en = 1'b1; step(1); tick_en = 1'b0;
    chk(rst_req, 1'b1, "R11 ninth tick expires");
    tick_en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; cfg_enable = 1'b0; cfg_period = '0;
    cfg_window = '0; cfg_no_reset = 1'b0; cfg_run_sleep = 1'b0; cfg_run_dbg = 1'b0;
    feed = 1'b0; sleep_in = 1'b0; dbg_halt = 1'b0; irq_en = 1'b0; tmo_clr = 1'b0;
    step(3);
    t_reset();
    rst_n = 1'b1; step(1);
    t_reset();
    t_period(4'd0);
    t_period(4'd2);
    t_period(4'd3);
    t_feed();
    t_window(4'd0, 3'd4);
    t_window(4'd2, 3'd7);
    t_window(4'd1, 3'd1);
    t_window_off();
    t_irq_mode();
    t_sleep(1'b0, 1'b0);
    t_sleep(1'b0, 1'b1);
    t_sleep(1'b1, 1'b0);
    t_sleep(1'b1, 1'b1);
    t_disable();
    t_tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule